// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a watchdog that a processor arms by writing two fixed key values, in order, to a control register. Once armed, it counts every clock on a counter that is two equal halves wide. If the count reaches a programmed period, or if software writes a key that is not one of the two valid values, the block raises a one-cycle reset request.

Software keeps an armed watchdog from firing by writing the first key and then the second key. That pair clears the counter. The block has only a write-side register bus and a clock, and its single output is the reset request. After it fires, it stays inert until the next system reset.

Counting needs the configuration register to select the watchdog mode and to set both run bits. The count and the period are each loaded one half at a time.

Top module: `wdt_keyseq`

## Requirements
- R1: After reset the block is disabled, the counter and the period are zero, and `rst_req` stays low until an armed timeout occurs.
- R2: A write to the control word (address 5) moves the block from disabled to pre-active only if two conditions hold together: bit 14 (enable) is 1, and bits [31:16] carry the arming key `ARM_KEY` (default 0xA5C6).
- R3: In pre-active, a control write whose key field equals `COMMIT_KEY` (default 0xDA7E) moves the block to active. The enable bit of that write does not matter.
- R4: In disabled and pre-active, a control write is ignored and leaves the state unchanged when its key is wrong, when it lacks the enable bit in disabled, or when it carries the commit key in disabled. No request results.
- R5: In active, a control write whose key is neither valid value causes a timeout: `rst_req` is high in the cycle after the write is sampled.
- R6: The counter advances by one per clock only when the configuration word (address 0) holds mode 2 in bits [1:0] and has both run bits (bit 8 and bit 9) set. Any other configuration freezes the counter.
- R7: The count is {high half (address 2), low half (address 1)} with a carry between the halves. The period is {address 4, address 3}. Writing a half loads it directly. In active, when the count equals the period, `rst_req` is high one cycle later.
- R8: In active, the arming key followed later by the commit key clears the whole counter, and the block stays active. A commit key that is not preceded by an arming key has no effect.
- R9: Once the block is active, no control write can disable it. A control word with bit 14 clear leaves the block armed.
- R10: `rst_req` is a single-cycle pulse. After a timeout the block holds a sticky tripped state with a frozen counter and gives no further request until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 3 | Word address of the write |
| wr_data | input | 32 | Write data |
| rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
The bench builds the block with `HALF_W = 8`, so the full count is 16 bits wide. With that width, periods of a few dozen to a few hundred clocks can be reached in short runs. A period of 260 puts the match beyond the low half, so the carry from the low half into the high half is exercised before the comparison succeeds. The key values keep their defaults, so the exact arming and commit words, and a wrong word, are driven as they would be in use.

// File: rtl/wdt_keyseq_pkg.sv
package wdt_keyseq_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 3;
  localparam int KEY_W   = 16;
  localparam int KEY_LSB = 16;
  localparam int EN_BIT  = 14;
  localparam int RUN_LO_BIT = 8;
  localparam int RUN_HI_BIT = 9;

  localparam logic [ADDR_W-1:0] A_CFG    = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
  localparam logic [ADDR_W-1:0] A_PER_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_PER_HI = 3'd4;
  localparam logic [ADDR_W-1:0] A_CTL    = 3'd5;

  localparam logic [1:0] MODE_WDOG = 2'd2;

  typedef enum logic [1:0] {ST_OFF, ST_PRE, ST_ACT, ST_TRIP} wd_state_e;
  typedef enum logic [1:0] {KEY_ARM, KEY_COMMIT, KEY_BAD} key_kind_e;

  function automatic key_kind_e classify_key(input logic [KEY_W-1:0] k,
                                             input logic [KEY_W-1:0] arm,
                                             input logic [KEY_W-1:0] commit);
    if (k == arm)         return KEY_ARM;
    else if (k == commit) return KEY_COMMIT;
    else                  return KEY_BAD;
  endfunction

  function automatic logic cfg_counts(input logic [1:0] mode,
                                      input logic run_lo, input logic run_hi);
    return (mode == MODE_WDOG) && run_lo && run_hi;
  endfunction
endpackage

// File: rtl/wdt_cfg_regs.sv
module wdt_cfg_regs
  import wdt_keyseq_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic                  cfg_run,
  output logic [2*HALF_W-1:0]   period,
  output logic                  ld_lo,
  output logic                  ld_hi,
  output logic                  ctl_wr
);
  logic [1:0] mode_q;
  logic       run_lo_q, run_hi_q;
  logic       unused_data;

  assign unused_data = ^wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      run_lo_q <= 1'b0;
      run_hi_q <= 1'b0;
    end else if (wr_en && wr_addr == A_CFG) begin
      mode_q   <= wr_data[1:0];
      run_lo_q <= wr_data[RUN_LO_BIT];
      run_hi_q <= wr_data[RUN_HI_BIT];
    end
  end

  // one period register per half
  for (genvar h = 0; h < 2; h++) begin : g_per
    localparam logic [ADDR_W-1:0] MY_ADDR = (h == 0) ? A_PER_LO : A_PER_HI;
    always_ff @(posedge clk) begin
      if (!rst_n)
        period[h*HALF_W +: HALF_W] <= '0;
      else if (wr_en && wr_addr == MY_ADDR)
        period[h*HALF_W +: HALF_W] <= wr_data[HALF_W-1:0];
    end
  end

  assign cfg_run = cfg_counts(mode_q, run_lo_q, run_hi_q);
  assign ld_lo   = wr_en && (wr_addr == A_CNT_LO);
  assign ld_hi   = wr_en && (wr_addr == A_CNT_HI);
  assign ctl_wr  = wr_en && (wr_addr == A_CTL);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int HALF_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                clear,
  input  logic                ld_lo,
  input  logic                ld_hi,
  input  logic [HALF_W-1:0]   ld_val,
  output logic [2*HALF_W-1:0] cnt
);
  localparam int CNT_W = 2 * HALF_W;

  logic [CNT_W-1:0] nxt;

  // priority: clear, then a half load, then the increment
  always_comb begin
    nxt = cnt;
    if (clear)      nxt = '0;
    else if (ld_lo) nxt = {cnt[CNT_W-1:HALF_W], ld_val};
    else if (ld_hi) nxt = {ld_val, cnt[HALF_W-1:0]};
    else if (run)   nxt = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= nxt;
  end
endmodule

// File: rtl/wdt_key_fsm.sv
module wdt_key_fsm
  import wdt_keyseq_pkg::*;
#(
  parameter logic [15:0] ARM_KEY    = 16'hA5C6,
  parameter logic [15:0] COMMIT_KEY = 16'hDA7E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] ctl_data,
  input  logic              match,
  output wd_state_e         state,
  output logic              ev_service,
  output logic              ev_bad,
  output logic              ev_match,
  output logic              rst_req
);
  key_kind_e kind;
  wd_state_e nstate;
  logic      armed_q;
  logic      en_bit;
  logic      fire;
  logic      unused_ctl;

  assign unused_ctl = ^ctl_data;
  assign kind   = classify_key(ctl_data[KEY_LSB +: KEY_W], ARM_KEY, COMMIT_KEY);
  assign en_bit = ctl_data[EN_BIT];

  assign ev_bad     = (state == ST_ACT) && ctl_wr && (kind == KEY_BAD);
  assign ev_match   = (state == ST_ACT) && match;
  assign ev_service = (state == ST_ACT) && ctl_wr && (kind == KEY_COMMIT) && armed_q;
  assign fire       = ev_bad || ev_match;

  always_comb begin
    nstate = state;
    unique case (state)
      ST_OFF:  if (ctl_wr && en_bit && kind == KEY_ARM) nstate = ST_PRE;
      ST_PRE:  if (ctl_wr && kind == KEY_COMMIT)        nstate = ST_ACT;
      ST_ACT:  if (fire)                                nstate = ST_TRIP;
      ST_TRIP: nstate = ST_TRIP;
      default: nstate = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_OFF;
      armed_q <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      state   <= nstate;
      rst_req <= fire;
      if (state == ST_ACT && ctl_wr) begin
        if (kind == KEY_ARM)         armed_q <= 1'b1;
        else if (kind == KEY_COMMIT) armed_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
  import wdt_keyseq_pkg::*;
#(
  parameter int          HALF_W     = 32,
  parameter logic [15:0] ARM_KEY    = 16'hA5C6,
  parameter logic [15:0] COMMIT_KEY = 16'hDA7E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [31:0]       wr_data,
  output logic              rst_req
);
  localparam int CNT_W = 2 * HALF_W;

  logic             cfg_run, ld_lo, ld_hi, ctl_wr;
  logic [CNT_W-1:0] period, cnt;
  wd_state_e        st;
  logic             ev_service, ev_bad, ev_match;
  logic             run_eff, match;

  wdt_cfg_regs #(.HALF_W(HALF_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_run(cfg_run), .period(period), .ld_lo(ld_lo), .ld_hi(ld_hi), .ctl_wr(ctl_wr)
  );

  assign run_eff = cfg_run && (st != ST_TRIP);
  assign match   = (cnt == period);

  wdt_counter #(.HALF_W(HALF_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_eff), .clear(ev_service),
    .ld_lo(ld_lo && st != ST_TRIP), .ld_hi(ld_hi && st != ST_TRIP),
    .ld_val(wr_data[HALF_W-1:0]), .cnt(cnt)
  );

  wdt_key_fsm #(.ARM_KEY(ARM_KEY), .COMMIT_KEY(COMMIT_KEY)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(wr_data), .match(match),
    .state(st), .ev_service(ev_service), .ev_bad(ev_bad), .ev_match(ev_match),
    .rst_req(rst_req)
  );
endmodule

// File: rtl/wdt_keyseq_chk.sv
module wdt_keyseq_chk
  import wdt_keyseq_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input wd_state_e        state,
  input logic             ev_bad,
  input logic             ev_match,
  input logic             ev_service,
  input logic [CNT_W-1:0] cnt,
  input logic             rst_req
);
  p_bad_key_fires_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad |=> rst_req);
  p_match_fires_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_match |=> rst_req);
  p_service_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_service |=> (cnt == '0));
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_ACT) |=> !rst_req);
  p_stays_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACT) |=> (state == ST_ACT || state == ST_TRIP));
  p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  p_trip_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TRIP) |=> (state == ST_TRIP && $stable(cnt)));
  p_pre_from_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PRE) |=> (state == ST_PRE || state == ST_ACT));
endmodule

bind wdt_keyseq wdt_keyseq_chk #(.CNT_W(2*HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(st), .ev_bad(ev_bad), .ev_match(ev_match),
  .ev_service(ev_service), .cnt(cnt), .rst_req(rst_req)
);

// File: tb/wdt_keyseq_tb_top.sv
`timescale 1ns/1ps
module wdt_keyseq_tb_top;
  localparam int HW = 8;
  localparam logic [15:0] KA = 16'hA5C6;
  localparam logic [15:0] KC = 16'hDA7E;
  localparam logic [15:0] KX = 16'h1234;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rst_req;

  int checks = 0;
  int errors = 0;
  int neg_n = 0;
  int drive_n = 0;
  int unexp = 0;
  int exp_q[$];
  string tag_q[$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdt_keyseq #(.HALF_W(HW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rst_req(rst_req)
  );

  function automatic logic [31:0] ctl(input logic [15:0] k, input logic en);
    return {k, 1'b0, en, 14'd0};
  endfunction
  function automatic logic [31:0] cfg(input logic [1:0] m, input logic rl, input logic rh);
    return {22'd0, rh, rl, 6'd0, m};
  endfunction

  // monitor: pops expected pulse slots, flags any pulse outside a slot
  always @(negedge clk) begin
    neg_n++;
    if (exp_q.size() > 0 && exp_q[0] == neg_n) begin
      checks++;
      if (rst_req !== 1'b1) begin
        errors++;
        $display("FAIL %s: rst_req=%b expected 1 at slot %0d", tag_q[0], rst_req, neg_n);
      end
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end else if (rst_req !== 1'b0) begin
      unexp++;
      checks++;
      errors++;
      $display("FAIL R10: rst_req=%b expected 0 at slot %0d", rst_req, neg_n);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    drive_n = neg_n;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic expect_pulse(input int off, input string tag);
    exp_q.push_back(drive_n + off);
    tag_q.push_back(tag);
  endtask

  task automatic quiet(input int cyc, input string tag);
    int start;
    start = unexp;
    repeat (cyc) @(posedge clk);
    #1;
    checks++;
    if (unexp != start) begin
      errors++;
      $display("FAIL %s: %0d unexpected pulses, expected 0", tag, unexp - start);
    end
  endtask

  task automatic drain(input string tag);
    int n = 0;
    while (exp_q.size() > 0 && n < 2000) begin
      @(posedge clk); n++;
    end
    #1;
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s: %0d expected pulses missing, expected 0", tag, exp_q.size());
      exp_q.delete(); tag_q.delete();
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  task automatic setup(input int per, input logic [1:0] m, input logic rl, input logic rh);
    wr(3'd4, 32'(per >> HW));
    wr(3'd3, 32'(per & ((1 << HW) - 1)));
    wr(3'd2, 32'd0);
    wr(3'd1, 32'd0);
    wr(3'd0, cfg(m, rl, rh));
  endtask

  task automatic activate();
    wr(3'd5, ctl(KA, 1'b1));
    wr(3'd5, ctl(KC, 1'b0));
  endtask

  initial begin
    @(posedge clk); #1;
    do_reset();
    // R1: quiet after reset
    quiet(30, "R1");

    // R2/R3/R4/R5: key ordering in disabled and pre-active
    setup(200, 2'd2, 1'b1, 1'b1);
    wr(3'd5, ctl(KX, 1'b1));
    quiet(5, "R4 bad key while disabled");
    wr(3'd5, ctl(KA, 1'b0));
    wr(3'd5, ctl(KC, 1'b1));
    wr(3'd5, ctl(KX, 1'b1));
    quiet(5, "R2 arm key without enable");
    wr(3'd5, ctl(KA, 1'b1));
    wr(3'd5, ctl(KX, 1'b0));
    quiet(5, "R4 bad key while pre-active");
    wr(3'd5, ctl(KC, 1'b0));
    wr(3'd5, ctl(KX, 1'b0));
    expect_pulse(2, "R5 bad key while active");
    drain("R3 activation then R5");
    wr(3'd5, ctl(KX, 1'b1));
    quiet(300, "R10 sticky after trip");

    // R7: match timeout
    do_reset();
    setup(40, 2'd2, 1'b1, 1'b1);
    activate();
    wr(3'd1, 32'd5);
    expect_pulse(3 + 40 - 5, "R7 period match");
    drain("R7");
    quiet(100, "R10 no second pulse");

    // R8/R9: service and enable hold
    do_reset();
    setup(40, 2'd2, 1'b1, 1'b1);
    activate();
    wr(3'd1, 32'd30);
    wr(3'd5, ctl(KC, 1'b0));
    wr(3'd5, ctl(KA, 1'b0));
    wr(3'd5, ctl(KC, 1'b0));
    expect_pulse(3 + 40, "R8 service clears counter");
    quiet(30, "R9 still armed, not yet due");
    drain("R8");

    // R6: counting gated by configuration
    do_reset();
    setup(30, 2'd2, 1'b1, 1'b0);
    activate();
    wr(3'd1, 32'd0);
    quiet(60, "R6 one run bit missing");
    wr(3'd0, cfg(2'd1, 1'b1, 1'b1));
    quiet(60, "R6 wrong mode");
    wr(3'd0, cfg(2'd2, 1'b1, 1'b1));
    expect_pulse(2 + 30 + 1, "R6 counting once configured");
    drain("R6");

    // R7: carry across halves
    do_reset();
    setup(260, 2'd2, 1'b1, 1'b1);
    activate();
    wr(3'd2, 32'd0);
    wr(3'd1, 32'd250);
    expect_pulse(3 + 260 - 250, "R7 carry into high half");
    drain("R7 carry");

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule